// File: doc/BRIEF.md
# Interval Clock and Watchdog Timer

This block is a real-time clock peripheral that a processor drives with single-cycle I/O commands. Each command has one of four classes: control, skip test, input or output. It carries a 4-bit function code and the accumulator value. The clock has a 16-bit interval register that software loads with a negative count. A working counter starts from that value and is incremented once per timebase tick. A tick corresponds to 3.2 us of real time, set by a cycles-per-tick parameter. When the counter rolls over to zero, the block raises a pending interrupt and reloads the counter from the interval register, so that periodic interrupts continue without software help.

The interrupt request leaves through an interrupt mask, together with a programmable vector address. A separate watchdog counts a fixed 50 ms window (a parameter in ticks) from its own timebase. It flags a timeout unless software restarts it or stops it first. Input commands return the interval register, a device identifier merged into the accumulator, and two front-panel switch words. Every command gets a registered response one cycle later. The response carries the data word and a skip flag.

Top module: `pic_clock_wd`

## Requirements
- R1: After reset, irq, wd_expire and rsp_valid are 0, irq_vector is 0 and the interval register reads 0.
- R2: An output command (class 3) with function 2 loads the interval register and the working counter from io_wdata. An input command (class 2) with function 2 returns the interval register. Input and output commands never set rsp_skip.
- R3: While the clock runs, the counter advances once every CLK_PER_TICK cycles, counted from the start command. Loaded with -N, the counter raises the pending interrupt at the edge N*CLK_PER_TICK cycles after the start edge.
- R4: On rolling over to zero, the counter reloads from the interval register. The next interrupt comes another N*CLK_PER_TICK cycles later without any reload by software.
- R5: Control function 1 acknowledges (clears) the pending interrupt. Control function 0 starts the clock and control function 2 stops it, and both also clear the pending interrupt. A stopped clock raises no interrupt.
- R6: Control function 015 (octal) sets the interrupt mask and 016 clears it. irq is the pending flag gated by the mask, and clearing the mask does not discard the pending flag.
- R7: A skip command (class 1) with function 0 skips when irq is 1, and with function 2 skips when irq is 0.
- R8: An output command with function 013 (octal) sets irq_vector to io_wdata.
- R9: An input command with function 011 (octal) returns io_wdata ORed with the identifier 0120 (octal). Function 016 returns sw_up and function 017 returns sw_down.
- R10: Control function 6 clears wd_expire and starts a watchdog window of WDOG_TICKS ticks, and issuing it again restarts the window. At the end of the window, wd_expire becomes 1 and skip function 5 skips. Control function 7 stops the watchdog before it expires.
- R11: Control function 017 (octal) returns every register to its reset state: the clock is stopped, the mask is clear, the vector and interval are 0, and the watchdog is stopped and not expired.
- R12: Each command sampled with io_valid high produces rsp_valid for exactly the next cycle, with its rsp_data and rsp_skip. rsp_valid is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | Command strobe, one cycle per command |
| io_class | input | 2 | 0 control, 1 skip, 2 input, 3 output |
| io_func | input | 4 | Function code |
| io_wdata | input | 16 | Accumulator value sent with the command |
| sw_up | input | 16 | Up-position switch word |
| sw_down | input | 16 | Momentary-down switch word |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 16 | Response data for input commands |
| rsp_skip | output | 1 | Skip result of the command |
| irq | output | 1 | Masked interrupt request |
| irq_vector | output | 16 | Interrupt vector address |
| wd_expire | output | 1 | Watchdog timeout flag |

## Verification
The assertions assume that io_class, io_func and io_wdata are known whenever io_valid is high, and that commands arrive only while reset is released. They also assume that an acknowledge is not meant to win against a rollover in the same cycle. The bench keeps to these assumptions by issuing one command at a time, from the falling edge and held for a single cycle. Every timed check is placed at a count of edges measured from the start or restart command. The interval sweep covers counts from -1 to -6 with a four-cycle tick, and the watchdog is tested with a window of ten ticks.

// File: rtl/pic_clock_pkg.sv
package pic_clock_pkg;

  localparam int FUNC_W = 4;

  typedef enum logic [1:0] {
    CLS_CTL  = 2'd0,
    CLS_SKIP = 2'd1,
    CLS_IN   = 2'd2,
    CLS_OUT  = 2'd3
  } io_class_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic ack;
    logic wd_start;
    logic wd_stop;
    logic mask_set;
    logic mask_clr;
    logic mclear;
    logic ld_interval;
    logic ld_vector;
  } pic_ctl_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_INTERVAL,
    RD_ID,
    RD_SW_UP,
    RD_SW_DN
  } rd_sel_e;

  typedef enum logic [1:0] {
    SK_NEVER,
    SK_IRQ,
    SK_NOIRQ,
    SK_WDOG
  } sk_sel_e;

endpackage

// File: rtl/pic_decode.sv
module pic_decode
  import pic_clock_pkg::*;
(
  input  logic                  valid,
  input  logic [1:0]            cls,
  input  logic [FUNC_W-1:0]     func,
  output pic_ctl_t              ctl,
  output rd_sel_e               rd_sel,
  output sk_sel_e               sk_sel
);

  always_comb begin
    ctl    = '0;
    rd_sel = RD_NONE;
    sk_sel = SK_NEVER;
    if (valid) begin
      unique case (io_class_e'(cls))
        CLS_CTL: begin
          case (func)
            4'o00: ctl.start    = 1'b1;
            4'o01: ctl.ack      = 1'b1;
            4'o02: ctl.stop     = 1'b1;
            4'o06: ctl.wd_start = 1'b1;
            4'o07: ctl.wd_stop  = 1'b1;
            4'o15: ctl.mask_set = 1'b1;
            4'o16: ctl.mask_clr = 1'b1;
            4'o17: ctl.mclear   = 1'b1;
            default: ;
          endcase
        end
        CLS_SKIP: begin
          case (func)
            4'o00: sk_sel = SK_IRQ;
            4'o02: sk_sel = SK_NOIRQ;
            4'o05: sk_sel = SK_WDOG;
            default: sk_sel = SK_NEVER;
          endcase
        end
        CLS_IN: begin
          case (func)
            4'o02: rd_sel = RD_INTERVAL;
            4'o11: rd_sel = RD_ID;
            4'o16: rd_sel = RD_SW_UP;
            4'o17: rd_sel = RD_SW_DN;
            default: rd_sel = RD_NONE;
          endcase
        end
        CLS_OUT: begin
          case (func)
            4'o02: ctl.ld_interval = 1'b1;
            4'o13: ctl.ld_vector   = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pic_timebase.sv
module pic_timebase #(
  parameter int DIV = 640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = at_last & ~clr;

  always_comb begin
    if (clr || at_last) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pic_interval.sv
module pic_interval #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic         stop,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         mclear,
  output logic [W-1:0] interval,
  output logic         wrap
);

  logic [W-1:0] ivl_q, ivl_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         step;

  assign step     = run_q & tick;
  assign wrap     = step & (&cnt_q) & ~load & ~mclear;
  assign interval = ivl_q;

  always_comb begin
    ivl_d = ivl_q;
    cnt_d = cnt_q;
    run_d = run_q;
    if (mclear) begin
      ivl_d = '0;
      cnt_d = '0;
      run_d = 1'b0;
    end else begin
      if (start)     run_d = 1'b1;
      else if (stop) run_d = 1'b0;
      if (load) begin
        ivl_d = load_val;
        cnt_d = load_val;
      end else if (wrap) begin
        cnt_d = ivl_q;
      end else if (step) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      ivl_q <= ivl_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/pic_wdog.sv
module pic_wdog #(
  parameter int TICKS = 15625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic stop,
  input  logic mclear,
  output logic expired,
  output logic running
);

  localparam int WCW = $clog2(TICKS + 1);
  localparam logic [WCW-1:0] LAST = WCW'(TICKS - 1);

  logic [WCW-1:0] cnt_q, cnt_d;
  logic           run_q, run_d;
  logic           exp_q, exp_d;

  assign expired = exp_q;
  assign running = run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    exp_d = exp_q;
    if (mclear) begin
      cnt_d = '0;
      run_d = 1'b0;
      exp_d = 1'b0;
    end else if (start) begin
      cnt_d = '0;
      run_d = 1'b1;
      exp_d = 1'b0;
    end else if (stop) begin
      run_d = 1'b0;
    end else if (run_q && tick) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        run_d = 1'b0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      exp_q <= exp_d;
    end
  end

endmodule

// File: rtl/pic_clock_wd.sv
module pic_clock_wd
  import pic_clock_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CLK_PER_TICK = 640,
  parameter int WDOG_TICKS   = 15625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic [1:0]        io_class,
  input  logic [3:0]        io_func,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] sw_up,
  input  logic [DATA_W-1:0] sw_down,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_skip,
  output logic              irq,
  output logic [DATA_W-1:0] irq_vector,
  output logic              wd_expire
);

  localparam logic [DATA_W-1:0] DEV_ID = DATA_W'(8'o120);

  pic_ctl_t ctl;
  rd_sel_e  rd_sel;
  sk_sel_e  sk_sel;

  logic              clk_tick, wd_tick;
  logic              iv_wrap, wd_run;
  logic [DATA_W-1:0] interval;

  logic              pend_q, pend_d;
  logic              mask_q, mask_d;
  logic [DATA_W-1:0] vec_q, vec_d;
  logic              rv_q, rv_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              sk_q, sk_d;

  pic_decode u_dec (
    .valid  (io_valid),
    .cls    (io_class),
    .func   (io_func),
    .ctl    (ctl),
    .rd_sel (rd_sel),
    .sk_sel (sk_sel)
  );

  pic_timebase #(.DIV(CLK_PER_TICK)) u_clk_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.start | ctl.mclear),
    .tick  (clk_tick)
  );

  pic_timebase #(.DIV(CLK_PER_TICK)) u_wd_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.wd_start | ctl.mclear),
    .tick  (wd_tick)
  );

  pic_interval #(.W(DATA_W)) u_ivl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (clk_tick),
    .start    (ctl.start),
    .stop     (ctl.stop),
    .load     (ctl.ld_interval),
    .load_val (io_wdata),
    .mclear   (ctl.mclear),
    .interval (interval),
    .wrap     (iv_wrap)
  );

  pic_wdog #(.TICKS(WDOG_TICKS)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (wd_tick),
    .start   (ctl.wd_start),
    .stop    (ctl.wd_stop),
    .mclear  (ctl.mclear),
    .expired (wd_expire),
    .running (wd_run)
  );

  assign irq = pend_q & mask_q;

  // interrupt state: a rollover in the same cycle as an acknowledge survives
  always_comb begin
    pend_d = pend_q;
    mask_d = mask_q;
    vec_d  = vec_q;
    if (ctl.mclear) begin
      pend_d = 1'b0;
      mask_d = 1'b0;
      vec_d  = '0;
    end else begin
      if (iv_wrap)                               pend_d = 1'b1;
      else if (ctl.ack || ctl.start || ctl.stop) pend_d = 1'b0;
      if (ctl.mask_set)      mask_d = 1'b1;
      else if (ctl.mask_clr) mask_d = 1'b0;
      if (ctl.ld_vector)     vec_d  = io_wdata;
    end
  end

  // response path
  always_comb begin
    rv_d = io_valid;
    unique case (rd_sel)
      RD_INTERVAL: rd_d = interval;
      RD_ID:       rd_d = io_wdata | DEV_ID;
      RD_SW_UP:    rd_d = sw_up;
      RD_SW_DN:    rd_d = sw_down;
      default:     rd_d = '0;
    endcase
    unique case (sk_sel)
      SK_IRQ:   sk_d = irq;
      SK_NOIRQ: sk_d = ~irq;
      SK_WDOG:  sk_d = wd_expire;
      default:  sk_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mask_q <= 1'b0;
      vec_q  <= '0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
      sk_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      vec_q  <= vec_d;
      rv_q   <= rv_d;
      rd_q   <= rd_d;
      sk_q   <= sk_d;
    end
  end

  assign irq_vector = vec_q;
  assign rsp_valid  = rv_q;
  assign rsp_data   = rd_q;
  assign rsp_skip   = sk_q;

endmodule

// File: rtl/pic_clock_wd_chk.sv
module pic_clock_wd_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_valid,
  input logic [1:0]        io_class,
  input logic [3:0]        io_func,
  input logic [DATA_W-1:0] io_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_skip,
  input logic              irq,
  input logic [DATA_W-1:0] irq_vector,
  input logic              wd_expire,
  input logic              mask_q,
  input logic              wrap,
  input logic              wd_run
);

  logic is_ctl, is_skip, is_in, is_out;
  assign is_ctl  = io_valid && io_class == 2'd0;
  assign is_skip = io_valid && io_class == 2'd1;
  assign is_in   = io_valid && io_class == 2'd2;
  assign is_out  = io_valid && io_class == 2'd3;

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid |=> rsp_valid);
  p_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |=> !rsp_valid);
  p_noskip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_in || is_out) |=> !rsp_skip);
  p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctl && io_func == 4'o01 && !wrap) |=> !irq);
  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q);
  p_skip_sense_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_skip && io_func == 4'o00) |=> (rsp_skip == $past(irq)));
  p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out && io_func == 4'o13) |=> (irq_vector == $past(io_wdata)));
  p_id_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_in && io_func == 4'o11) |=> (rsp_data == ($past(io_wdata) | DATA_W'(8'o120))));
  p_wd_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctl && io_func == 4'o07) |=> !wd_run);
  p_wd_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |-> !wd_run);
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctl && io_func == 4'o17) |=> (!irq && !wd_expire && irq_vector == '0));

endmodule

bind pic_clock_wd pic_clock_wd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_valid   (io_valid),
  .io_class   (io_class),
  .io_func    (io_func),
  .io_wdata   (io_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .rsp_skip   (rsp_skip),
  .irq        (irq),
  .irq_vector (irq_vector),
  .wd_expire  (wd_expire),
  .mask_q     (mask_q),
  .wrap       (iv_wrap),
  .wd_run     (wd_run)
);

// File: tb/pic_clock_wd_bench.sv
module pic_clock_wd_bench;

  localparam int DIV = 4;
  localparam int WDT = 10;
  localparam logic [1:0] C_CTL = 2'd0, C_SKP = 2'd1, C_IN = 2'd2, C_OUT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0;
  logic [1:0]  io_class = '0;
  logic [3:0]  io_func = '0;
  logic [15:0] io_wdata = '0;
  logic [15:0] sw_up = 16'hA5C3;
  logic [15:0] sw_down = 16'h0F0F;
  logic        rsp_valid, rsp_skip, irq, wd_expire;
  logic [15:0] rsp_data, irq_vector;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pic_clock_wd #(.DATA_W(16), .CLK_PER_TICK(DIV), .WDOG_TICKS(WDT)) u_pic_clock_wd (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_class(io_class),
    .io_func(io_func), .io_wdata(io_wdata), .sw_up(sw_up), .sw_down(sw_down),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_skip(rsp_skip),
    .irq(irq), .irq_vector(irq_vector), .wd_expire(wd_expire)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [3:0] f, input logic [15:0] d);
    io_valid = 1'b1; io_class = c; io_func = f; io_wdata = d;
    @(posedge clk);
    @(negedge clk);
    io_valid = 1'b0;
  endtask

  task automatic wait_e(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R12 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    wait_e(3);
    rst_n = 1'b1;
    wait_e(1);

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 wd_expire", {15'd0, wd_expire}, 16'd0);
    check("R1 vector", irq_vector, 16'd0);
    check("R1 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    issue(C_IN, 4'o02, 16'hFFFF);
    check("R1 interval", rsp_data, 16'd0);
    check("R12 rsp_valid", {15'd0, rsp_valid}, 16'd1);
    wait_e(1);
    check("R12 rsp_valid drop", {15'd0, rsp_valid}, 16'd0);

    // R2 interval load and read back
    issue(C_OUT, 4'o02, 16'hFFF0);
    check("R2 out noskip", {15'd0, rsp_skip}, 16'd0);
    issue(C_IN, 4'o02, 16'h0);
    check("R2 readback", rsp_data, 16'hFFF0);
    check("R2 in noskip", {15'd0, rsp_skip}, 16'd0);

    // R8 vector
    issue(C_OUT, 4'o13, 16'o1234);
    check("R8 vector", irq_vector, 16'o1234);

    // R9 identifier and switches
    issue(C_IN, 4'o11, 16'h1000);
    check("R9 id merge", rsp_data, 16'h1050);
    issue(C_IN, 4'o11, 16'h0050);
    check("R9 id or", rsp_data, 16'h0050);
    issue(C_IN, 4'o16, 16'h0);
    check("R9 sw_up", rsp_data, 16'hA5C3);
    issue(C_IN, 4'o17, 16'h0);
    check("R9 sw_down", rsp_data, 16'h0F0F);

    // R3 sweep of interval lengths
    for (int n = 1; n <= 6; n++) begin
      issue(C_CTL, 4'o17, 16'h0);
      issue(C_OUT, 4'o02, 16'(-n));
      issue(C_CTL, 4'o15, 16'h0);
      issue(C_CTL, 4'o00, 16'h0);
      wait_e(n * DIV - 1);
      check("R3 before rollover", {15'd0, irq}, 16'd0);
      wait_e(1);
      check("R3 at rollover", {15'd0, irq}, 16'd1);
    end

    // R4 automatic reload (N=6, rollover at k+24)
    issue(C_CTL, 4'o01, 16'h0);
    check("R5 ack", {15'd0, irq}, 16'd0);
    wait_e(22);
    check("R4 before second", {15'd0, irq}, 16'd0);
    wait_e(1);
    check("R4 second rollover", {15'd0, irq}, 16'd1);

    // R7 skip tests
    issue(C_SKP, 4'o00, 16'h0);
    check("R7 skip on irq", {15'd0, rsp_skip}, 16'd1);
    issue(C_SKP, 4'o02, 16'h0);
    check("R7 no skip on not-irq", {15'd0, rsp_skip}, 16'd0);
    issue(C_CTL, 4'o01, 16'h0);
    issue(C_SKP, 4'o00, 16'h0);
    check("R7 no skip idle", {15'd0, rsp_skip}, 16'd0);
    issue(C_SKP, 4'o02, 16'h0);
    check("R7 skip idle", {15'd0, rsp_skip}, 16'd1);

    // R5 stop
    issue(C_CTL, 4'o02, 16'h0);
    wait_e(60);
    check("R5 stopped", {15'd0, irq}, 16'd0);
    issue(C_IN, 4'o02, 16'h0);
    check("R5 interval kept", rsp_data, 16'(-6));

    // R6 mask gating
    issue(C_CTL, 4'o17, 16'h0);
    issue(C_OUT, 4'o02, 16'(-20));
    issue(C_CTL, 4'o00, 16'h0);
    wait_e(80);
    check("R6 masked", {15'd0, irq}, 16'd0);
    issue(C_CTL, 4'o15, 16'h0);
    check("R6 mask set", {15'd0, irq}, 16'd1);
    issue(C_CTL, 4'o16, 16'h0);
    check("R6 mask clr", {15'd0, irq}, 16'd0);
    issue(C_CTL, 4'o15, 16'h0);
    check("R6 pending kept", {15'd0, irq}, 16'd1);
    issue(C_CTL, 4'o00, 16'h0);
    check("R5 start acks", {15'd0, irq}, 16'd0);
    issue(C_CTL, 4'o02, 16'h0);

    // R10 watchdog
    issue(C_CTL, 4'o06, 16'h0);
    wait_e(WDT * DIV - 1);
    check("R10 before expiry", {15'd0, wd_expire}, 16'd0);
    wait_e(1);
    check("R10 expiry", {15'd0, wd_expire}, 16'd1);
    issue(C_SKP, 4'o05, 16'h0);
    check("R10 skip expired", {15'd0, rsp_skip}, 16'd1);
    issue(C_CTL, 4'o06, 16'h0);
    check("R10 restart clears", {15'd0, wd_expire}, 16'd0);
    issue(C_SKP, 4'o05, 16'h0);
    check("R10 no skip", {15'd0, rsp_skip}, 16'd0);
    wait_e(20);
    issue(C_CTL, 4'o07, 16'h0);
    wait_e(60);
    check("R10 stopped", {15'd0, wd_expire}, 16'd0);
    issue(C_CTL, 4'o06, 16'h0);
    wait_e(30);
    issue(C_CTL, 4'o06, 16'h0);
    wait_e(WDT * DIV - 1);
    check("R10 restart window", {15'd0, wd_expire}, 16'd0);
    wait_e(1);
    check("R10 restart expiry", {15'd0, wd_expire}, 16'd1);

    // R11 master clear
    issue(C_OUT, 4'o13, 16'h0777);
    issue(C_OUT, 4'o02, 16'hFFFF);
    issue(C_CTL, 4'o15, 16'h0);
    issue(C_CTL, 4'o00, 16'h0);
    wait_e(DIV);
    check("R11 setup irq", {15'd0, irq}, 16'd1);
    issue(C_CTL, 4'o17, 16'h0);
    check("R11 irq", {15'd0, irq}, 16'd0);
    check("R11 vector", irq_vector, 16'd0);
    check("R11 wd_expire", {15'd0, wd_expire}, 16'd0);
    issue(C_IN, 4'o02, 16'h0);
    check("R11 interval", rsp_data, 16'd0);
    issue(C_CTL, 4'o15, 16'h0);
    wait_e(100);
    check("R11 clock stopped", {15'd0, irq}, 16'd0);
    check("R11 wdog stopped", {15'd0, wd_expire}, 16'd0);

    finish_run();
  end

endmodule